// File: doc/BRIEF.md
# Compare Timer With Prescaled Tick Sources

This block is a peripheral up-counter with three compare channels and a single level interrupt. Software picks one of three tick-source strobes, divides it with a programmable prescaler and lets the counter run either freely through its full range or in a restart mode where compare channel 1 sets the period. Compare matches and counter rollover raise status flags that software clears by writing ones.

Access is through a small word-addressed bus: one select, one write strobe, a word index and 32-bit data in each direction. A write completes in the clock cycle where it is presented. Read data is combinational from the same index. The counter width is a parameter with a default of 32 bits. The tick sources are single-cycle strobes in the block's own clock domain.

Top module: `cmp_timer`

## Requirements
- R1: After reset, control, prescaler, status, enable and counter read zero, the three compare registers read all ones, and irq_o is low.
- R2: A control write stores the word with bits 2, 4, 10, 11, 12, 13, 14 and 15 forced to zero. Bit 0 is enable, bit 1 is enable-mode, bits 8:6 select the source and bit 9 selects free-run.
- R3: Source code 001 selects src_tick_i[0], 010 selects src_tick_i[1] and 100 selects src_tick_i[2]. Every other code selects nothing. The counter moves only on a tick and only while the enable bit is set.
- R4: The prescaler register is 12 bits. The counter advances once for every prescaler+1 strobes of the selected source, and a prescaler write restarts the division.
- R5: In the status register, bits 0 to 2 are the compare 1 to 3 flags, bits 3 and 4 are capture flags that are never set, and bit 5 is rollover. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: The interrupt-enable register stores only bits 5:0, with the same bit layout as status.
- R7: The flag of compare channel k is set when a tick moves the counter onto the value of compare k while enable bit k is set. With that enable bit clear, the flag stays clear.
- R8: In free-run, the counter goes from all ones to zero, and the rollover flag is set if enable bit 5 is set.
- R9: With free-run clear, a tick taken while the counter equals compare 1 returns the counter to zero, and any write to compare 1 clears the counter. In free-run, a compare 1 write leaves the counter alone.
- R10: Setting the enable bit while enable-mode is written as 1 clears the counter. Otherwise re-enabling resumes from the held value.
- R11: Writing control with bit 15 set clears control bits 0 to 5, keeps the other stored bits, and clears the prescaler, status, interrupt enable and counter. It also sets all compare registers to all ones.
- R12: irq_o is high exactly while some status bit and its enable bit are both set and the control enable bit is set.
- R13: The word offsets are 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4 to 6 compare 1 to 3, 7 and 8 capture, and 9 counter. Capture reads zero. The counter ignores writes. Any other offset reads zero and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 3 | Tick strobes: peripheral, fast peripheral, 32 kHz |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | Write strobe, qualified by select |
| bus_addr_i | input | 4 | Word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, zero when not selected |
| irq_o | output | 1 | Level interrupt |

## Verification
The rollover path is the hardest case to reach, because the counter cannot be loaded and a 32-bit wrap takes about four billion ticks. The bench therefore builds the block with an 8-bit counter and drives the selected strobe for the exact number of cycles needed to pass the top value. Restart-mode periods, compare flags and the enable-mode restart are reached the same way, with strobes held for known cycle counts. Random register traffic, with the source strobes held low, checks the write masks, software reset and the map against a bench model.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int FLAG_W  = 6;
  localparam int N_CMP   = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFF_CTRL = 4'd0, OFF_PSC  = 4'd1, OFF_STAT = 4'd2, OFF_IEN  = 4'd3,
    OFF_CMP1 = 4'd4, OFF_CMP2 = 4'd5, OFF_CMP3 = 4'd6,
    OFF_CAP1 = 4'd7, OFF_CAP2 = 4'd8, OFF_CNT  = 4'd9
  } reg_off_e;

  localparam int CB_EN    = 0;
  localparam int CB_EMODE = 1;
  localparam int CB_SRC   = 6;
  localparam int CB_FREE  = 9;
  localparam int CB_SWR   = 15;

  localparam logic [DATA_W-1:0] CTRL_ZERO_MASK = 32'h0000_FC14;
  localparam logic [DATA_W-1:0] CTRL_SWR_CLR   = 32'h0000_003F;

  localparam int SB_ROV = 5;

  localparam logic [2:0] SRC_PERIPH = 3'b001;
  localparam logic [2:0] SRC_FAST   = 3'b010;
  localparam logic [2:0] SRC_SLOW   = 3'b100;
endpackage

// File: rtl/cmp_timer_tick.sv
module cmp_timer_tick
  import cmp_timer_pkg::*;
#(
  parameter int PSC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       src_i,
  input  logic [2:0]       sel_i,
  input  logic [PSC_W-1:0] div_i,
  input  logic             run_i,
  input  logic             clr_i,
  output logic             tick_o
);
  logic             hit;
  logic [PSC_W-1:0] pcnt_q;
  logic             wrap;

  always_comb begin
    unique case (sel_i)
      SRC_PERIPH: hit = src_i[0];
      SRC_FAST:   hit = src_i[1];
      SRC_SLOW:   hit = src_i[2];
      default:    hit = 1'b0;
    endcase
  end

  assign wrap   = (pcnt_q == div_i);
  assign tick_o = run_i & hit & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pcnt_q <= '0;
    else if (clr_i)       pcnt_q <= '0;
    else if (run_i & hit) pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
  end

  assert_psc_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> pcnt_q <= div_i);
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic                          zero_i,
  input  logic                          free_i,
  input  logic [N_CMP-1:0][CNT_W-1:0]   cmp_i,
  output logic [CNT_W-1:0]              cnt_o,
  output logic [N_CMP-1:0]              hit_o,
  output logic                          wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             restart, at_max, step;

  assign at_max  = (cnt_q == CNT_MAX);
  assign restart = ~free_i & (cnt_q == cmp_i[0]);
  assign cnt_nxt = (restart | at_max) ? '0 : cnt_q + 1'b1;
  assign step    = tick_i & ~zero_i;
  assign wrap_o  = step & at_max;

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    assign hit_o[k] = step & (cnt_nxt == cmp_i[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (zero_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  assert_cnt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !zero_i |=> $stable(cnt_q));
  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && !free_i && cnt_q == cmp_i[0] |=> cnt_q == '0);
  assert_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && cnt_q == CNT_MAX |=> cnt_q == '0);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        src_tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0]              ctrl_q, ctrl_w;
  logic [PSC_W-1:0]               psc_q;
  logic [FLAG_W-1:0]              stat_q, ien_q, set_flags, clr_flags;
  logic [N_CMP-1:0][CNT_W-1:0]    cmp_q;
  logic [CNT_W-1:0]               cnt;
  logic [N_CMP-1:0]               hit;
  logic                           wrap, tick;
  logic                           wr, wr_ctrl, wr_psc, wr_stat, wr_ien, swr;
  logic [N_CMP-1:0]               wr_cmp;
  logic                           en_rise, zero_cnt;

  assign wr      = bus_sel_i & bus_we_i;
  assign wr_ctrl = wr & (bus_addr_i == OFF_CTRL);
  assign wr_psc  = wr & (bus_addr_i == OFF_PSC);
  assign wr_stat = wr & (bus_addr_i == OFF_STAT);
  assign wr_ien  = wr & (bus_addr_i == OFF_IEN);
  assign wr_cmp[0] = wr & (bus_addr_i == OFF_CMP1);
  assign wr_cmp[1] = wr & (bus_addr_i == OFF_CMP2);
  assign wr_cmp[2] = wr & (bus_addr_i == OFF_CMP3);

  assign swr     = wr_ctrl & bus_wdata_i[CB_SWR];
  assign ctrl_w  = bus_wdata_i & ~CTRL_ZERO_MASK & ~(swr ? CTRL_SWR_CLR : '0);
  assign en_rise = wr_ctrl & ~swr & ~ctrl_q[CB_EN] & bus_wdata_i[CB_EN] & bus_wdata_i[CB_EMODE];
  assign zero_cnt = swr | en_rise | (wr_cmp[0] & ~ctrl_q[CB_FREE]);

  cmp_timer_tick #(.PSC_W(PSC_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_tick_i),
    .sel_i  (ctrl_q[CB_SRC +: 3]),
    .div_i  (psc_q),
    .run_i  (ctrl_q[CB_EN]),
    .clr_i  (swr | wr_psc),
    .tick_o (tick)
  );

  cmp_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .zero_i (zero_cnt),
    .free_i (ctrl_q[CB_FREE]),
    .cmp_i  (cmp_q),
    .cnt_o  (cnt),
    .hit_o  (hit),
    .wrap_o (wrap)
  );

  // set wins over a same-cycle clear
  assign set_flags = {wrap & ien_q[SB_ROV], 2'b00, hit & ien_q[N_CMP-1:0]};
  assign clr_flags = wr_stat ? bus_wdata_i[FLAG_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      stat_q <= '0;
      ien_q  <= '0;
      cmp_q  <= '1;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_w;
      if (swr) begin
        psc_q  <= '0;
        stat_q <= '0;
        ien_q  <= '0;
        cmp_q  <= '1;
      end else begin
        if (wr_psc) psc_q <= bus_wdata_i[PSC_W-1:0];
        if (wr_ien) ien_q <= bus_wdata_i[FLAG_W-1:0];
        stat_q <= (stat_q & ~clr_flags) | set_flags;
        for (int k = 0; k < N_CMP; k++)
          if (wr_cmp[k]) cmp_q[k] <= bus_wdata_i[CNT_W-1:0];
      end
    end
  end

  assign irq_o = ctrl_q[CB_EN] & |(stat_q & ien_q);

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i) begin
      unique case (bus_addr_i)
        OFF_CTRL: bus_rdata_o = ctrl_q;
        OFF_PSC:  bus_rdata_o = DATA_W'(psc_q);
        OFF_STAT: bus_rdata_o = DATA_W'(stat_q);
        OFF_IEN:  bus_rdata_o = DATA_W'(ien_q);
        OFF_CMP1: bus_rdata_o = DATA_W'(cmp_q[0]);
        OFF_CMP2: bus_rdata_o = DATA_W'(cmp_q[1]);
        OFF_CMP3: bus_rdata_o = DATA_W'(cmp_q[2]);
        OFF_CNT:  bus_rdata_o = DATA_W'(cnt);
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  assert_ien_store_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ien |=> ien_q == $past(bus_wdata_i[FLAG_W-1:0]));
  assert_cap_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q[4:3] == 2'b00);
  assert_flag_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_q[1] && !ien_q[1] |=> !stat_q[1]);
  assert_rov_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_q[SB_ROV] && !ien_q[SB_ROV] |=> !stat_q[SB_ROV]);
  assert_en_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise |=> cnt == '0);
endmodule

// File: tb/cmp_timer_tb_top.sv
module cmp_timer_tb_top;
  localparam int CW = 8;
  localparam logic [31:0] CMAX = 32'h0000_00FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_ctrl, m_psc, m_ien;
  logic [31:0] m_cmp [3];

  always #4 clk = ~clk;

  cmp_timer #(.CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] f_ctrl(input logic [31:0] w);
    logic [31:0] v = w & ~32'h0000_FC14;
    if (w[15]) v &= ~32'h0000_003F;
    return v;
  endfunction

  function automatic logic [31:0] f_read(input logic [3:0] a);
    case (a)
      4'd0: return m_ctrl;
      4'd1: return m_psc;
      4'd3: return m_ien;
      4'd4: return m_cmp[0];
      4'd5: return m_cmp[1];
      4'd6: return m_cmp[2];
      default: return 32'h0;
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
    case (a)
      4'd0: begin
        m_ctrl = f_ctrl(d);
        if (d[15]) begin
          m_psc = 0; m_ien = 0;
          for (int k = 0; k < 3; k++) m_cmp[k] = CMAX;
        end
      end
      4'd1: m_psc = {20'h0, d[11:0]};
      4'd3: m_ien = {26'h0, d[5:0]};
      4'd4, 4'd5, 4'd6: m_cmp[a-4] = {24'h0, d[7:0]};
      default: ;
    endcase
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] m, input int n);
    @(negedge clk);
    src = m;
    repeat (n) @(negedge clk);
    src = '0;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd_reg(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a;
    void'($urandom(32'd1234));
    m_ctrl = 0; m_psc = 0; m_ien = 0;
    for (int k = 0; k < 3; k++) m_cmp[k] = CMAX;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 10; i++) chk_reg("R1", 4'(i), (i >= 4 && i <= 6) ? CMAX : 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // random register traffic, sources idle: R2 R6 R11 R13
    for (int i = 0; i < 300; i++) begin
      a = $urandom_range(0, 15);
      d = $urandom();
      if (a == 2) d = 32'h0;
      wr_reg(a[3:0], d);
      a = $urandom_range(0, 15);
      rd_reg(a[3:0], d);
      chk("R2/R6/R11/R13 map", d, f_read(a[3:0]));
      chk("R12 irq idle", {31'h0, irq}, 32'h0);
    end

    wr_reg(4'd0, 32'h0000_8000);
    chk_reg("R11 ctrl", 4'd0, m_ctrl);
    chk_reg("R11 psc", 4'd1, 32'h0);
    chk_reg("R11 ien", 4'd3, 32'h0);
    chk_reg("R11 cmp3", 4'd6, CMAX);
    chk_reg("R11 cnt", 4'd9, 32'h0);

    // R3 source selection and enable
    wr_reg(4'd0, 32'h0000_0241);
    pulse(3'b001, 10);
    chk_reg("R3 periph", 4'd9, 32'd10);
    pulse(3'b010, 5);
    chk_reg("R3 unselected", 4'd9, 32'd10);
    wr_reg(4'd0, 32'h0000_0280);
    pulse(3'b010, 4);
    chk_reg("R3 disabled", 4'd9, 32'd10);
    wr_reg(4'd0, 32'h0000_0281);
    pulse(3'b010, 4);
    chk_reg("R10 resume fast", 4'd9, 32'd14);
    wr_reg(4'd0, 32'h0000_0301);
    pulse(3'b100, 3);
    chk_reg("R3 slow", 4'd9, 32'd17);
    wr_reg(4'd0, 32'h0000_03C1);
    pulse(3'b111, 3);
    chk_reg("R3 code 111", 4'd9, 32'd17);

    // R4 prescaler
    wr_reg(4'd0, 32'h0000_0241);
    wr_reg(4'd1, 32'd2);
    pulse(3'b001, 9);
    chk_reg("R4 div3", 4'd9, 32'd20);
    pulse(3'b001, 2);
    chk_reg("R4 partial", 4'd9, 32'd20);
    pulse(3'b001, 1);
    chk_reg("R4 third", 4'd9, 32'd21);
    pulse(3'b001, 2);
    wr_reg(4'd1, 32'd2);
    pulse(3'b001, 2);
    chk_reg("R4 restart div", 4'd9, 32'd21);
    pulse(3'b001, 1);
    chk_reg("R4 after restart", 4'd9, 32'd22);
    wr_reg(4'd1, 32'd0);

    // R7 compare flags, R12 irq, R5 clear
    wr_reg(4'd5, 32'd30);
    pulse(3'b001, 8);
    chk_reg("R7 no enable cnt", 4'd9, 32'd30);
    chk_reg("R7 no enable flag", 4'd2, 32'h0);
    wr_reg(4'd3, 32'h02);
    wr_reg(4'd5, 32'd35);
    pulse(3'b001, 5);
    chk_reg("R7 flag", 4'd2, 32'h02);
    chk("R12 irq on", {31'h0, irq}, 32'h1);
    wr_reg(4'd0, 32'h0000_0240);
    chk("R12 gated", {31'h0, irq}, 32'h0);
    chk_reg("R12 flag held", 4'd2, 32'h02);
    wr_reg(4'd0, 32'h0000_0241);
    chk("R12 regated", {31'h0, irq}, 32'h1);
    wr_reg(4'd2, 32'h01);
    chk_reg("R5 write0 keeps", 4'd2, 32'h02);
    wr_reg(4'd2, 32'h02);
    chk_reg("R5 clear", 4'd2, 32'h0);
    chk("R12 off", {31'h0, irq}, 32'h0);

    // R8 rollover in free-run
    wr_reg(4'd3, 32'h20);
    pulse(3'b001, 221);
    chk_reg("R8 wrap cnt", 4'd9, 32'd0);
    chk_reg("R8 rov flag", 4'd2, 32'h20);
    chk("R8 irq", {31'h0, irq}, 32'h1);
    wr_reg(4'd2, 32'h3F);

    // R9 restart mode
    wr_reg(4'd0, 32'h0000_0041);
    wr_reg(4'd3, 32'h01);
    wr_reg(4'd4, 32'd4);
    chk_reg("R9 cmp1 write clears", 4'd9, 32'd0);
    pulse(3'b001, 4);
    chk_reg("R9 at cmp1", 4'd9, 32'd4);
    chk_reg("R7 cmp1 flag", 4'd2, 32'h01);
    pulse(3'b001, 1);
    chk_reg("R9 restart", 4'd9, 32'd0);
    pulse(3'b001, 4);
    wr_reg(4'd0, 32'h0000_0241);
    wr_reg(4'd4, 32'd9);
    chk_reg("R9 free keeps", 4'd9, 32'd4);

    // R10 enable-mode restart
    wr_reg(4'd0, 32'h0000_0240);
    wr_reg(4'd0, 32'h0000_0243);
    chk_reg("R10 restart", 4'd9, 32'd0);
    pulse(3'b001, 3);
    chk_reg("R10 runs", 4'd9, 32'd3);

    // R11 partial control clear
    wr_reg(4'd3, 32'h3F);
    wr_reg(4'd0, 32'h0001_8243);
    chk_reg("R11 ctrl keep", 4'd0, 32'h0001_0240);
    chk_reg("R11 cnt", 4'd9, 32'h0);
    chk_reg("R11 ien", 4'd3, 32'h0);
    chk_reg("R11 cmp1", 4'd4, CMAX);
    chk_reg("R11 stat", 4'd2, 32'h0);

    // R13 read-only counter, capture, unmapped
    wr_reg(4'd0, 32'h0000_0241);
    pulse(3'b001, 2);
    wr_reg(4'd9, 32'h55);
    chk_reg("R13 cnt ro", 4'd9, 32'd2);
    chk_reg("R13 cap1", 4'd7, 32'h0);
    chk_reg("R13 cap2", 4'd8, 32'h0);
    wr_reg(4'd12, 32'hFFFF_FFFF);
    chk_reg("R13 unmapped", 4'd12, 32'h0);
    chk_reg("R13 ctrl intact", 4'd0, 32'h0000_0241);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule